// File: doc/BRIEF.md
# Reset Cause Capture Unit

This block remembers why a small microcontroller last came out of reset. It watches five digital inputs: an active-low external reset pin, a watchdog time-out strobe, a brown-out event, a live low-voltage comparator output and a stop-mode flag. Each accepted reset cause sets one sticky bit in an 8-bit status byte. A separate bit marks whether the device was in stop mode when that cause arrived. The external pin is first synchronised and then filtered. A low pulse has to last a parameterised number of clock cycles before it counts as a reset.

Software reads the status byte through a simple register port. A read returns the byte and clears the four cause bits. The lowest bit carries the live low-voltage condition, which is not latched and cannot be cleared. The status byte cannot be written: a write to its address is forwarded as a one-cycle watchdog control write. A low-voltage interrupt gives software the only reliable view of a short supply dip. When the brown-out detector is disabled, brown-out events, the low-voltage bit and the interrupt are all suppressed. Each accepted reset cause also produces a one-cycle reset request pulse for the rest of the chip.

Top module: `rst_status_unit`

## Requirements
- R1: After power-on reset (porN low), a read returns 0x80: bit 7 (brown-out/power-on cause) is set, and bits 6, 5 and 4 are clear.
- R2: A read (regSel and rdEn high for one cycle) returns {bit7..bit4, 3'b000, bit0}. After the read, bits 7 to 4 read zero. Bits 3 to 1 always read zero. rdData is 0 when no read is active.
- R3: An accepted cause replaces bits 7 to 5 with a one-hot code: brown-out = bit 7, external pin = bit 6, watchdog time-out = bit 5.
- R4: The external pin counts as a reset only if it is low for at least FILT_LEN consecutive clock cycles (default 4). A shorter low pulse changes no status bit and raises no reset request. A long pulse is accepted once.
- R5: Bit 4 is written with the stopMode input value at the cycle a cause is accepted, including a pin reset taken during stop mode.
- R6: When causes arrive in the same cycle, brown-out beats the pin, and the pin beats the watchdog. Only the winner's bit is set.
- R7: If a cause is accepted in the same cycle as a read, the read returns the old byte and the new cause remains set afterwards.
- R8: A write (regSel and wrEn) produces wdtCtlWr high for exactly the next cycle, with wdtCtlData equal to wrData. The status byte is unchanged.
- R9: Bit 0 equals lvdLow AND bodEnable at all times, and no read or write alters it.
- R10: lvdIrq is a single-cycle pulse, one cycle after a rising edge of (lvdLow AND bodEnable), and only if lvdIrqEn is high.
- R11: With bodEnable low, bodEvt is ignored, bit 0 reads zero and lvdIrq stays low.
- R12: rstReq pulses high for one cycle, one cycle after each accepted cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous active-low power-on reset |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog time-out strobe |
| bodEvt | input | 1 | Brown-out event strobe |
| bodEnable | input | 1 | Brown-out detector enable, also gates low-voltage detection |
| lvdLow | input | 1 | Live low-voltage comparator output |
| lvdIrqEn | input | 1 | Low-voltage interrupt enable |
| stopMode | input | 1 | Device is in stop mode |
| regSel | input | 1 | Register address select |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data for the watchdog control register |
| rdData | output | 8 | Status byte read data |
| wdtCtlData | output | 8 | Forwarded watchdog control data |
| wdtCtlWr | output | 1 | Watchdog control write pulse |
| lvdIrq | output | 1 | Low-voltage interrupt pulse |
| rstReq | output | 1 | Reset request pulse |

## Verification
The hardest cases to reach from the ports are two races. The first is a cause that lands in the same cycle as a read. The second is a pin pulse whose length sits exactly on the filter threshold, where one cycle decides between ignore and reset. The bench drives a watchdog strobe on the same falling edge that opens a read. It also sends pin pulses of FILT_LEN-1 and FILT_LEN cycles. On top of these, seeded random sequences mix pulse widths, stop-mode states, brown-out enables and reads, and all results are compared against a bench-side model of the status byte.

// File: rtl/rst_status_pkg.sv
package rst_status_pkg;
  localparam int REG_W    = 8;
  localparam int STICKY_W = 4;

  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic setPor;
    logic setPin;
    logic setWdt;
    logic stopFlag;
    logic clrSticky;
    logic wdtWrite;
  } statusStrobes_t;
endpackage

// File: rtl/rst_pin_filter.sv
module rst_pin_filter #(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  input  logic pinN,
  output logic pinEvt
);
  localparam int CNT_W = $clog2(FILT_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FILT_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_LEN - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       lowCnt;
  logic                   syncLow;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], pinN};
  end

  assign syncLow = ~syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                lowCnt <= '0;
    else if (!syncLow)        lowCnt <= '0;
    else if (lowCnt != CNT_FULL) lowCnt <= lowCnt + 1'b1;
  end

  assign pinEvt = syncLow && (lowCnt == CNT_LAST);

  // R4
  single_accept_chk: assert property (@(posedge clk) disable iff (!porN)
    pinEvt |=> !pinEvt);
  // R4
  high_rearms_chk: assert property (@(posedge clk) disable iff (!porN)
    !syncLow |=> !pinEvt);
endmodule

// File: rtl/rst_status_ctrl.sv
module rst_status_ctrl
  import rst_status_pkg::*;
(
  input  logic           clk,
  input  logic           porN,
  input  logic           bodEvt,
  input  logic           bodEnable,
  input  logic           pinEvt,
  input  logic           wdtTimeout,
  input  logic           stopMode,
  input  logic           rdStrobe,
  input  logic           wrStrobe,
  input  logic           lvdLow,
  input  logic           lvdIrqEn,
  output statusStrobes_t strobes,
  output logic           lvdLive,
  output logic           lvdIrq,
  output logic           rstReq
);
  logic bodHit;
  logic lvdPrev;

  assign bodHit = bodEvt & bodEnable;

  always_comb begin
    strobes           = '0;
    strobes.setPor    = bodHit;
    strobes.setPin    = pinEvt & ~bodHit;
    strobes.setWdt    = wdtTimeout & ~bodHit & ~pinEvt;
    strobes.stopFlag  = stopMode;
    strobes.clrSticky = rdStrobe;
    strobes.wdtWrite  = wrStrobe;
  end

  assign lvdLive = lvdLow & bodEnable;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      lvdPrev <= 1'b0;
      lvdIrq  <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      lvdPrev <= lvdLive;
      lvdIrq  <= lvdIrqEn & lvdLive & ~lvdPrev;
      rstReq  <= bodHit | pinEvt | wdtTimeout;
    end
  end

  // R11
  bod_off_quiet_chk: assert property (@(posedge clk) disable iff (!porN)
    !bodEnable |=> !lvdIrq);
  // R10
  irq_single_chk: assert property (@(posedge clk) disable iff (!porN)
    lvdIrq |=> !lvdIrq);
  // R12
  req_follows_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobes.setPor || strobes.setPin || strobes.setWdt) |=> rstReq);
endmodule

// File: rtl/rst_status_dp.sv
module rst_status_dp
  import rst_status_pkg::*;
(
  input  logic             clk,
  input  logic             porN,
  input  statusStrobes_t   strobes,
  input  logic [REG_W-1:0] wrData,
  input  logic             lvdLive,
  output logic [REG_W-1:0] rdData,
  output logic [REG_W-1:0] wdtCtlData,
  output logic             wdtCtlWr
);
  localparam logic [STICKY_W-1:0] POR_VALUE = 4'b1000;
  localparam int PAD_W = REG_W - STICKY_W - 1;

  logic [STICKY_W-1:0] sticky;
  logic                anySet;

  assign anySet = strobes.setPor | strobes.setPin | strobes.setWdt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                  sticky <= POR_VALUE;
    else if (anySet)            sticky <= {strobes.setPor, strobes.setPin,
                                           strobes.setWdt, strobes.stopFlag};
    else if (strobes.clrSticky) sticky <= '0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      wdtCtlWr   <= 1'b0;
      wdtCtlData <= '0;
    end else begin
      wdtCtlWr <= strobes.wdtWrite;
      if (strobes.wdtWrite) wdtCtlData <= wrData;
    end
  end

  assign rdData = strobes.clrSticky ? {sticky, {PAD_W{1'b0}}, lvdLive} : '0;

  // R2
  read_clears_chk: assert property (@(posedge clk) disable iff (!porN)
    (strobes.clrSticky && !anySet) |=> (sticky == '0));
  // R3
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!porN)
    $onehot0(sticky[STICKY_W-1:1]));
  // R8
  wdt_write_chk: assert property (@(posedge clk) disable iff (!porN)
    strobes.wdtWrite |=> (wdtCtlWr && $stable(sticky) || anySet || $past(anySet)));
endmodule

// File: rtl/rst_status_unit.sv
module rst_status_unit
  import rst_status_pkg::*;
#(
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       extRstN,
  input  logic       wdtTimeout,
  input  logic       bodEvt,
  input  logic       bodEnable,
  input  logic       lvdLow,
  input  logic       lvdIrqEn,
  input  logic       stopMode,
  input  logic       regSel,
  input  logic       rdEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic [7:0] wdtCtlData,
  output logic       wdtCtlWr,
  output logic       lvdIrq,
  output logic       rstReq
);
  statusStrobes_t strobes;
  logic pinEvt;
  logic lvdLive;

  rst_pin_filter #(.FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)) uFilt (
    .clk(clk), .porN(porN), .pinN(extRstN), .pinEvt(pinEvt)
  );

  rst_status_ctrl uCtrl (
    .clk(clk), .porN(porN), .bodEvt(bodEvt), .bodEnable(bodEnable),
    .pinEvt(pinEvt), .wdtTimeout(wdtTimeout), .stopMode(stopMode),
    .rdStrobe(regSel & rdEn), .wrStrobe(regSel & wrEn),
    .lvdLow(lvdLow), .lvdIrqEn(lvdIrqEn), .strobes(strobes),
    .lvdLive(lvdLive), .lvdIrq(lvdIrq), .rstReq(rstReq)
  );

  rst_status_dp uDp (
    .clk(clk), .porN(porN), .strobes(strobes), .wrData(wrData),
    .lvdLive(lvdLive), .rdData(rdData), .wdtCtlData(wdtCtlData),
    .wdtCtlWr(wdtCtlWr)
  );
endmodule

// File: tb/sim_rst_status_unit.sv
module sim_rst_status_unit;
  localparam int FILT = 4;

  logic clk = 1'b0;
  logic porN, extRstN, wdtTimeout, bodEvt, bodEnable, lvdLow, lvdIrqEn, stopMode;
  logic regSel, rdEn, wrEn;
  logic [7:0] wrData, rdData, wdtCtlData;
  logic wdtCtlWr, lvdIrq, rstReq;

  int checks = 0, fails = 0;
  int reqCnt = 0, irqCnt = 0;
  logic [3:0] expUp;
  bit done = 0;

  always #10 clk = ~clk;

  rst_status_unit #(.FILT_LEN(FILT)) u0 (
    .clk(clk), .porN(porN), .extRstN(extRstN), .wdtTimeout(wdtTimeout),
    .bodEvt(bodEvt), .bodEnable(bodEnable), .lvdLow(lvdLow), .lvdIrqEn(lvdIrqEn),
    .stopMode(stopMode), .regSel(regSel), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .wdtCtlData(wdtCtlData),
    .wdtCtlWr(wdtCtlWr), .lvdIrq(lvdIrq), .rstReq(rstReq)
  );

  always @(negedge clk) begin
    if (rstReq) reqCnt++;
    if (lvdIrq) irqCnt++;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expByte();
    return {expUp, 3'b000, lvdLow & bodEnable};
  endfunction

  task automatic doRead(input string tag);
    logic [7:0] e;
    regSel = 1; rdEn = 1;
    #1 e = expByte();
    check(rdData == e, tag, rdData, e);
    tick(1);
    regSel = 0; rdEn = 0;
    expUp = 4'b0000;
    #1 check(rdData == 8'h00, "R2 idle read data", rdData, 0);
  endtask

  task automatic pinPulse(input int w, input bit stp);
    int r0;
    r0 = reqCnt;
    stopMode = stp; extRstN = 0;
    tick(w);
    extRstN = 1;
    tick(FILT + 3);
    if (w >= FILT) begin
      expUp = {3'b010, stp};
      check(reqCnt == r0 + 1, "R4 R12 pin accepted once", reqCnt - r0, 1);
    end else begin
      check(reqCnt == r0, "R4 short pin ignored", reqCnt - r0, 0);
    end
    stopMode = 0;
  endtask

  task automatic wdtPulse(input bit stp);
    int r0;
    r0 = reqCnt;
    stopMode = stp; wdtTimeout = 1;
    tick(1);
    wdtTimeout = 0; stopMode = 0;
    tick(2);
    expUp = {3'b001, stp};
    check(reqCnt == r0 + 1, "R12 wdt request", reqCnt - r0, 1);
  endtask

  task automatic bodPulse(input bit stp);
    int r0;
    r0 = reqCnt;
    stopMode = stp; bodEvt = 1;
    tick(1);
    bodEvt = 0; stopMode = 0;
    tick(2);
    if (bodEnable) expUp = {3'b100, stp};
    check(reqCnt == r0 + (bodEnable ? 1 : 0), "R11 R12 bod request", reqCnt - r0, bodEnable ? 1 : 0);
  endtask

  task automatic doWrite(input logic [7:0] d);
    regSel = 1; wrEn = 1; wrData = d;
    tick(1);
    regSel = 0; wrEn = 0;
    check(wdtCtlWr == 1'b1, "R8 write pulse", wdtCtlWr, 1);
    check(wdtCtlData == d, "R8 write data", wdtCtlData, d);
    tick(1);
    check(wdtCtlWr == 1'b0, "R8 write pulse ends", wdtCtlWr, 0);
  endtask

  task automatic lvdPulse(input int w, input bit en);
    int i0;
    i0 = irqCnt;
    lvdIrqEn = en; lvdLow = 1;
    #1 check(rdData[0] == 1'b0, "R9 idle bit0", rdData, 0);
    doRead("R9 live low-voltage bit");
    tick(w);
    lvdLow = 0;
    tick(2);
    check(irqCnt == i0 + ((en && bodEnable) ? 1 : 0), "R10 R11 lvd interrupt count",
          irqCnt - i0, (en && bodEnable) ? 1 : 0);
    lvdIrqEn = 0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    porN = 0; extRstN = 1; wdtTimeout = 0; bodEvt = 0; bodEnable = 1;
    lvdLow = 0; lvdIrqEn = 0; stopMode = 0; regSel = 0; rdEn = 0; wrEn = 0; wrData = 0;
    expUp = 4'b1000;
    seed = $urandom(32'h5EED1234);
    tick(3);
    porN = 1;
    tick(2);

    doRead("R1 reset value 0x80");
    doRead("R2 cleared after read");

    pinPulse(FILT - 1, 0);
    doRead("R4 FILT-1 pulse leaves status");
    pinPulse(FILT, 0);
    doRead("R3 R4 pin cause bit6");
    pinPulse(FILT + 6, 1);
    doRead("R5 pin reset during stop mode");

    wdtPulse(0);
    doRead("R3 watchdog cause bit5");

    // R6: brown-out and watchdog in the same cycle
    bodEvt = 1; wdtTimeout = 1;
    tick(1);
    bodEvt = 0; wdtTimeout = 0;
    tick(1);
    expUp = 4'b1000;
    doRead("R6 brown-out beats watchdog");

    // R7: watchdog accepted in the same cycle as a read
    bodPulse(0);
    regSel = 1; rdEn = 1; wdtTimeout = 1;
    #1 check(rdData == 8'h80, "R7 read returns old byte", rdData, 8'h80);
    tick(1);
    regSel = 0; rdEn = 0; wdtTimeout = 0;
    expUp = 4'b0010;
    tick(1);
    doRead("R7 new cause survives read");

    wdtPulse(1);
    doWrite(8'hA5);
    doRead("R8 write leaves status");

    lvdPulse(1, 1);
    doRead("R9 transient dip not latched");
    bodEnable = 0;
    lvdPulse(2, 1);
    bodPulse(0);
    doRead("R11 disabled brown-out ignored");
    bodEnable = 1;

    for (int it = 0; it < 250; it++) begin
      int op;
      op = $urandom_range(0, 6);
      case (op)
        0: pinPulse($urandom_range(1, 7), 1'($urandom_range(0, 1)));
        1: wdtPulse(1'($urandom_range(0, 1)));
        2: begin
             bodEnable = ($urandom_range(0, 3) != 0);
             bodPulse(1'($urandom_range(0, 1)));
           end
        3: doRead("R2 R3 R5 random read");
        4: doWrite(8'($urandom));
        5: lvdPulse($urandom_range(1, 3), 1'($urandom_range(0, 1)));
        default: tick(1);
      endcase
    end
    bodEnable = 1;
    doRead("R2 final read");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule